// File: doc/BRIEF.md
# Shared-Buffer Self-Routing Cell Switch Element

This block is one 8-by-8 switching element for the routing stages of a multistage cell fabric. Cells arrive on up to eight inputs in a cycle. Each cell has a 32-bit header and a payload whose width is a parameter. Every accepted cell is written into one common pool of cell slots. The element reads a 3-bit slice of the cell's destination port to choose a local output. The `STAGE` parameter selects the slice, starting with the most significant group. Each output sends at most one cell per cycle. Cells bound for the same output leave oldest first.

The element never drops a cell. Flow control is per link. After each cycle the element registers one congestion bit per input, and an asserted bit forbids the upstream stage from sending on that input in the next cycle. Each output has its own downstream congestion input. While that input is asserted, the element holds every cell bound for that output.

Send permits come from the free slots that remain after the cycle's arrivals and departures. Permits never exceed the free slot count. When slots are scarce, inputs that have no cell in the pool are served first. This brings cells from more sources into the pool and reduces head-of-line blocking.

Top module: `shbuf_route_elem`

## Requirements
- R1: Header bits [8:0] hold the destination port. Bits [31:23], [22:14] and [13:9] hold the source port, packet ID and sequence number, and the element carries them unchanged. The element at stage s forwards to local output dest[8-3s:6-3s]. With the default stage 0, destination 309 goes to output 4.
- R2: The element captures a cell at a clock edge. If its output is free and uncongested, the cell appears with identical header and payload on that output's registered port after the next edge.
- R3: Each output presents at most one cell per cycle. Cells for one output leave in arrival order. Among cells that arrive in the same cycle, the lower input index counts as older.
- R4: The element does not present a cell on an output whose downstream congestion input was high in the cycle before the presenting edge.
- R5: During reset, every output valid is 0 and every input congestion bit is 1.
- R6: If more than 8 slots are free after a cycle's arrivals and departures, every congestion bit clears, whatever the more-to-send inputs are.
- R7: If 8 or fewer slots are free, permits go only to inputs whose more-to-send is high. Inputs with zero cells in the pool are served first, in ascending index, and the other requesting inputs follow in ascending index. The number of cleared congestion bits never exceeds the free slot count.
- R8: Every cell sent on an uncongested input is stored and later delivered exactly once.
- R9: A cell sent on an input whose congestion bit is high is a protocol error.
- R10: The congestion bits after an edge count the slots freed by the cells presented at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NP | Per-input cell valid |
| in_hdr | input | NP x 32 | Per-input cell header |
| in_pay | input | NP x PAY_W | Per-input cell payload |
| in_more | input | NP | Per-input more-to-send request from upstream |
| cong_out | output | NP | Per-input congestion; high forbids sending next cycle |
| ds_cong | input | NP | Per-output congestion from the downstream stage |
| out_valid | output | NP | Per-output cell valid |
| out_hdr | output | NP x 32 | Per-output cell header |
| out_pay | output | NP x PAY_W | Per-output cell payload |

## Verification
A lone cell with destination 309 checks the header slice and the two-edge latency. Traffic spread over all outputs, with scattered downstream stalls, checks that blocked outputs hold their cells and that unblocked ones keep moving. All inputs aiming at one output checks oldest-first order, including the input-index tie-break within one cycle. A fill phase runs with every output stalled and only half the inputs requesting. Releasing a single output then frees one slot per cycle, so the scarce permits must go first to the idle inputs that just began requesting.

// File: rtl/shbuf_pkg.sv
package shbuf_pkg;
  localparam int HDR_W    = 32;
  localparam int DEST_W   = 9;
  localparam int DEST_LSB = 0;

  typedef struct packed {
    logic [8:0] src_port;
    logic [8:0] pkt_id;
    logic [4:0] seq_no;
    logic [8:0] dest;
  } cell_hdr_t;

  // lowest header bit of the destination group read by a given routing stage
  function automatic int grp_lsb(input int stage, input int grp_w);
    return DEST_LSB + DEST_W - grp_w * (stage + 1);
  endfunction
endpackage

// File: rtl/shbuf_slot_alloc.sv
module shbuf_slot_alloc #(
  parameter int NP    = 8,
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]           free_mask,
  input  logic [NP-1:0]              req,
  output logic [NP-1:0][IDX_W-1:0]   slot,
  output logic [NP-1:0]              ok
);
  logic [DEPTH-1:0] avail;

  always_comb begin
    avail = free_mask;
    slot  = '0;
    ok    = '0;
    for (int i = 0; i < NP; i++) begin
      if (req[i]) begin
        for (int e = 0; e < DEPTH; e++) begin
          if (avail[e] && !ok[i]) begin
            ok[i]   = 1'b1;
            slot[i] = IDX_W'(e);
          end
        end
        if (ok[i]) avail[slot[i]] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/shbuf_head_pick.sv
module shbuf_head_pick #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] hit,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  assign found = |hit;

  always_comb begin
    idx = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (hit[e]) idx = IDX_W'(e);
    end
  end

  // R3: rank bookkeeping leaves exactly one oldest cell per output
  a_r3_single_head: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/shbuf_cong_grant.sv
module shbuf_cong_grant #(
  parameter int NP    = 8,
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] free_cnt,
  input  logic [NP-1:0]    more,
  input  logic [NP-1:0]    zero,
  output logic [NP-1:0]    cong
);
  logic [CNT_W-1:0] budget;

  always_comb begin
    budget = free_cnt;
    cong   = '1;
    if (free_cnt > CNT_W'(NP)) begin
      cong = '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (more[i] && zero[i] && (budget != '0)) begin
          cong[i] = 1'b0;
          budget  = budget - CNT_W'(1);
        end
      end
      for (int i = 0; i < NP; i++) begin
        if (more[i] && !zero[i] && (budget != '0)) begin
          cong[i] = 1'b0;
          budget  = budget - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/shbuf_route_elem.sv
module shbuf_route_elem
  import shbuf_pkg::*;
#(
  parameter int NP    = 8,
  parameter int DEPTH = 64,
  parameter int PAY_W = 32,
  parameter int STAGE = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NP-1:0]                 in_valid,
  input  logic [NP-1:0][HDR_W-1:0]      in_hdr,
  input  logic [NP-1:0][PAY_W-1:0]      in_pay,
  input  logic [NP-1:0]                 in_more,
  output logic [NP-1:0]                 cong_out,
  input  logic [NP-1:0]                 ds_cong,
  output logic [NP-1:0]                 out_valid,
  output logic [NP-1:0][HDR_W-1:0]      out_hdr,
  output logic [NP-1:0][PAY_W-1:0]      out_pay
);
  localparam int PW      = $clog2(NP);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int GRP_LSB = grp_lsb(STAGE, PW);

  // slot pool state
  logic [DEPTH-1:0]                ent_v_q, ent_v_d;
  logic [DEPTH-1:0][IDX_W-1:0]     ent_rank_q, ent_rank_d;
  logic [DEPTH-1:0][PW-1:0]        ent_port_q, ent_src_q;
  logic [DEPTH-1:0][HDR_W-1:0]     ent_hdr_q;
  logic [DEPTH-1:0][PAY_W-1:0]     ent_pay_q;
  logic [NP-1:0][CNT_W-1:0]        ocnt_q, ocnt_d, icnt_q, icnt_d;
  logic [CNT_W-1:0]                occ_q, occ_d, free_d;
  logic [NP-1:0]                   cong_q, cong_d, outv_q;
  logic [NP-1:0][HDR_W-1:0]        out_hdr_q;
  logic [NP-1:0][PAY_W-1:0]        out_pay_q;

  // per-cycle control
  logic [NP-1:0][PW-1:0]           arr_port;
  logic [NP-1:0][IDX_W-1:0]        slot;
  logic [NP-1:0]                   slot_ok, arr, dep, hd_found, zero_d;
  logic [NP-1:0][DEPTH-1:0]        hit;
  logic [NP-1:0][IDX_W-1:0]        hd_idx;
  logic [DEPTH-1:0]                wr_en;
  logic [DEPTH-1:0][PW-1:0]        wr_sel;
  logic [CNT_W-1:0]                rank_tmp;
  logic                            proto_err;

  always_comb begin
    for (int i = 0; i < NP; i++) arr_port[i] = in_hdr[i][GRP_LSB +: PW];
  end

  shbuf_slot_alloc #(.NP(NP), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_alloc (
    .free_mask (~ent_v_q),
    .req       (in_valid),
    .slot      (slot),
    .ok        (slot_ok)
  );

  assign arr = in_valid & slot_ok;

  // an entry is the head of its output when its rank (older cells ahead) is zero
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      for (int e = 0; e < DEPTH; e++) begin
        hit[o][e] = ent_v_q[e] && (ent_port_q[e] == PW'(o)) && (ent_rank_q[e] == '0);
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_head
    shbuf_head_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit[o]),
      .found (hd_found[o]),
      .idx   (hd_idx[o])
    );
  end

  assign dep = hd_found & ~ds_cong;

  // next state: departures first, then arrivals take ranks behind survivors
  always_comb begin
    ent_v_d    = ent_v_q;
    ent_rank_d = ent_rank_q;
    icnt_d     = icnt_q;
    wr_en      = '0;
    wr_sel     = '0;
    rank_tmp   = '0;
    for (int o = 0; o < NP; o++) ocnt_d[o] = ocnt_q[o] - CNT_W'(dep[o]);
    for (int e = 0; e < DEPTH; e++) begin
      if (ent_v_q[e] && dep[ent_port_q[e]]) begin
        if (ent_rank_q[e] == '0) begin
          ent_v_d[e]             = 1'b0;
          icnt_d[ent_src_q[e]]   = icnt_d[ent_src_q[e]] - CNT_W'(1);
        end else begin
          ent_rank_d[e] = ent_rank_q[e] - IDX_W'(1);
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (arr[i]) begin
        rank_tmp                = ocnt_d[arr_port[i]];
        ent_v_d[slot[i]]        = 1'b1;
        ent_rank_d[slot[i]]     = rank_tmp[IDX_W-1:0];
        ocnt_d[arr_port[i]]     = ocnt_d[arr_port[i]] + CNT_W'(1);
        icnt_d[i]               = icnt_d[i] + CNT_W'(1);
        wr_en[slot[i]]          = 1'b1;
        wr_sel[slot[i]]         = PW'(i);
      end
    end
    occ_d  = occ_q + CNT_W'($countones(arr)) - CNT_W'($countones(dep));
    free_d = CNT_W'(DEPTH) - occ_d;
    for (int i = 0; i < NP; i++) zero_d[i] = (icnt_d[i] == '0);
  end

  shbuf_cong_grant #(.NP(NP), .CNT_W(CNT_W)) u_grant (
    .free_cnt (free_d),
    .more     (in_more),
    .zero     (zero_d),
    .cong     (cong_d)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v_q    <= '0;
      ent_rank_q <= '0;
      ocnt_q     <= '0;
      icnt_q     <= '0;
      occ_q      <= '0;
      cong_q     <= '1;
      outv_q     <= '0;
    end else begin
      ent_v_q    <= ent_v_d;
      ent_rank_q <= ent_rank_d;
      ocnt_q     <= ocnt_d;
      icnt_q     <= icnt_d;
      occ_q      <= occ_d;
      cong_q     <= cong_d;
      outv_q     <= dep;
    end
  end

  // datapath registers, enabled writes only
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (wr_en[e]) begin
        ent_hdr_q[e]  <= in_hdr[wr_sel[e]];
        ent_pay_q[e]  <= in_pay[wr_sel[e]];
        ent_port_q[e] <= arr_port[wr_sel[e]];
        ent_src_q[e]  <= wr_sel[e];
      end
    end
    for (int o = 0; o < NP; o++) begin
      if (dep[o]) begin
        out_hdr_q[o] <= ent_hdr_q[hd_idx[o]];
        out_pay_q[o] <= ent_pay_q[hd_idx[o]];
      end
    end
  end

  assign cong_out  = cong_q;
  assign out_valid = outv_q;
  assign out_hdr   = out_hdr_q;
  assign out_pay   = out_pay_q;
  assign proto_err = |(in_valid & cong_q);

  // R4: a stalled downstream link receives nothing
  a_r4_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (outv_q & $past(ds_cong)) == '0);
  // R7: permits never exceed the free slots
  a_r7_grant_within_free: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~cong_q) + int'(occ_q)) <= DEPTH);
  // R8: a permitted arrival always finds a slot
  a_r8_arrival_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid & ~cong_q & ~slot_ok) == '0);
  // R9: upstream must honour congestion
  a_r9_no_send_into_cong: assert property (@(posedge clk) disable iff (!rst_n)
    !proto_err);
endmodule

// File: tb/tb_shbuf_route_elem.sv
module tb_shbuf_route_elem;
  localparam int NP    = 8;
  localparam int DEPTH = 64;
  localparam int PAY_W = 32;

  typedef struct packed {
    logic [31:0] hdr;
    logic [31:0] pay;
    logic [2:0]  src;
  } exp_t;

  logic                     clk;
  logic                     rst_n;
  logic [NP-1:0]            in_valid, in_more, cong_out, ds_cong, out_valid;
  logic [NP-1:0][31:0]      in_hdr, out_hdr;
  logic [NP-1:0][PAY_W-1:0] in_pay, out_pay;

  shbuf_route_elem #(.NP(NP), .DEPTH(DEPTH), .PAY_W(PAY_W), .STAGE(0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_pay(in_pay),
    .in_more(in_more), .cong_out(cong_out), .ds_cong(ds_cong),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_pay(out_pay)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  exp_t             sbq [NP][$];
  int               n_chk, n_err;
  bit               finished;
  logic [8:0]       pkt_id;
  logic [31:0]      pay_ser;
  logic [NP-1:0][8:0] d;
  exp_t             mon_it;
  int               mon_cnt [NP];
  int               mon_occ, mon_free, mon_b;
  logic [NP-1:0]    mon_exp;

  task automatic check_eq(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int total_q();
    int t = 0;
    for (int o = 0; o < NP; o++) t += sbq[o].size();
    return t;
  endfunction

  // driver: one cycle of stimulus, honouring congestion, feeding the scoreboard
  task automatic send_cycle(input logic [NP-1:0] want, input logic [NP-1:0][8:0] dst,
                            input logic [NP-1:0] more, input logic [NP-1:0] ds);
    logic [31:0] h;
    @(negedge clk);
    ds_cong = ds;
    in_more = more;
    for (int i = 0; i < NP; i++) begin
      if (want[i] && !cong_out[i]) begin
        h = {9'(i), pkt_id, 5'd0, dst[i]};
        in_hdr[i]   = h;
        in_pay[i]   = pay_ser;
        in_valid[i] = 1'b1;
        sbq[dst[i][8:6]].push_back({h, pay_ser, 3'(i)});
        pkt_id  = pkt_id + 9'd1;
        pay_ser = pay_ser + 32'h0001_0203;
      end else begin
        in_valid[i] = 1'b0;
      end
    end
  endtask

  task automatic drain();
    for (int c = 0; c < 400; c++) begin
      send_cycle('0, '0, '0, '0);
      if (total_q() == 0) break;
    end
    send_cycle('0, '0, '0, '0);
    send_cycle('0, '0, '0, '0);
  endtask

  // monitor: compares every presented cell and the congestion vector each cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        for (int o = 0; o < NP; o++) begin
          if (out_valid[o]) begin
            check_eq({63'd0, ds_cong[o]}, 64'd0, "R4 cell presented on stalled output");
            if (sbq[o].size() == 0) begin
              check_eq(64'd1, 64'd0, "R8 cell presented with none expected");
            end else begin
              mon_it = sbq[o].pop_front();
              check_eq({out_hdr[o], out_pay[o]}, {mon_it.hdr, mon_it.pay}, "R2/R3 cell content or order");
            end
          end
        end
        mon_occ = 0;
        for (int i = 0; i < NP; i++) mon_cnt[i] = 0;
        for (int o = 0; o < NP; o++) begin
          for (int k = 0; k < sbq[o].size(); k++) begin
            mon_occ++;
            mon_cnt[sbq[o][k].src]++;
          end
        end
        mon_free = DEPTH - mon_occ;
        mon_exp  = '1;
        if (mon_free > NP) begin
          mon_exp = '0;
        end else begin
          mon_b = mon_free;
          for (int i = 0; i < NP; i++)
            if (in_more[i] && mon_cnt[i] == 0 && mon_b > 0) begin mon_exp[i] = 1'b0; mon_b--; end
          for (int i = 0; i < NP; i++)
            if (in_more[i] && mon_cnt[i] != 0 && mon_b > 0) begin mon_exp[i] = 1'b0; mon_b--; end
        end
        check_eq({56'd0, cong_out}, {56'd0, mon_exp}, "R6/R7/R10 congestion vector");
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; finished = 1'b0;
    pkt_id = '0; pay_ser = 32'hA500_0000;
    rst_n = 1'b0; in_valid = '0; in_hdr = '0; in_pay = '0; in_more = '0; ds_cong = '0;
    repeat (3) @(posedge clk);
    #2;
    check_eq({56'd0, cong_out}, {56'd0, 8'hFF}, "R5 congestion during reset");
    check_eq({56'd0, out_valid}, 64'd0, "R5 valid during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check_eq({56'd0, cong_out}, 64'd0, "R6 all permits with empty pool");

    // R1/R2: lone cell, destination 309 on input 2
    d = '0;
    d[2] = 9'd309;
    send_cycle(8'b0000_0100, d, '0, '0);
    send_cycle('0, '0, '0, '0);
    @(posedge clk);
    #2;
    check_eq({56'd0, out_valid}, {56'd0, 8'h10}, "R1 destination 309 on output 4");
    check_eq({55'd0, out_hdr[4][8:0]}, 64'd309, "R2 header carried through");
    check_eq({32'd0, out_hdr[4][31:23], 23'd0}, {32'd0, 9'd2, 23'd0}, "R1 source field kept");
    drain();

    // spread traffic with scattered downstream stalls (R4, R3)
    for (int c = 0; c < 60; c++) begin
      for (int i = 0; i < NP; i++) d[i] = 9'((i * 67 + c * 29 + c * i * 5) % 512);
      send_cycle('1, d, '1, (c % 7 == 3 || c % 11 == 5) ? 8'h5A : 8'h00);
    end
    drain();
    check_eq(64'(total_q()), 64'd0, "R8 spread traffic fully delivered");

    // hot spot: every input to output 3 (R3 ordering)
    for (int c = 0; c < 12; c++) begin
      for (int i = 0; i < NP; i++) d[i] = {3'd3, 6'(i * 5 + c)};
      send_cycle('1, d, '1, '0);
    end
    drain();
    check_eq(64'(total_q()), 64'd0, "R3 hot spot fully delivered");

    // fill with every output stalled, half the inputs requesting (R7)
    for (int c = 0; c < 20; c++) begin
      for (int i = 0; i < NP; i++) d[i] = {3'((i + c) % 8), 6'(c)};
      send_cycle(8'h0F, d, 8'h0F, '1);
    end
    send_cycle('0, '0, 8'h0F, '1);
    check_eq({56'd0, cong_out}, {56'd0, 8'hFF}, "R7 full pool blocks all inputs");
    check_eq(64'(total_q()), 64'(DEPTH), "R8 pool filled without loss");

    // release one output: single freed slot goes to idle requesting inputs first (R7)
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < NP; i++) d[i] = {3'd5, 6'(i)};
      send_cycle('1, d, '1, 8'hDF);
    end
    drain();
    check_eq(64'(total_q()), 64'd0, "R8 all cells delivered after release");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule